// File: doc/BRIEF.md
# Pseudo-Static RAM Device Model

A synthesizable, cycle-sampled model of a 16-bit asynchronous pseudo-static RAM. The asynchronous control pins are sampled on a free-running reference clock. They are a chip select of each polarity, write strobe, output strobe and one enable per byte lane. From the sampled pins the model decides standby, read, output-disabled or write behaviour. Read data is presented with a per-lane drive enable, so the surrounding logic can build the tri-state data bus. Storage is kept at a smaller parameterized depth than the address port; the upper address bits alias.

A write lasts as long as a lane's write overlap holds. That overlap is strobe low, both chip selects asserted, and that lane's enable low. The lane commits when its overlap ends, whichever qualifier releases first. A monitor watches for reads whose address keeps changing faster than one read cycle for longer than the hidden-refresh window. It raises a sticky flag when that happens.

Top module: `psram_model`

## Requirements
- R1: When the sampled pins show ce1_ni high, ce2_i low, or be_ni equal to 2'b11, standby_o is 1 and dq_oe_o is 2'b00. Outputs follow the pins sampled at the previous rising edge of clk_i.
- R2: Selected with we_ni high and oe_ni low, lane l is driven (dq_oe_o[l]=1) exactly when be_ni[l] is low. Lane 0 is dq_o[7:0] and lane 1 is dq_o[15:8], and each driven lane carries the stored byte.
- R3: Every lane whose dq_oe_o bit is 0 reads as zero on dq_o.
- R4: Selected with we_ni high and oe_ni high, no lane is driven and standby_o is 0.
- R5: Selected with we_ni low, no lane is driven whatever oe_ni is, and standby_o is 0.
- R6: A lane's write commits, at the edge where its overlap is seen to end, the dq_i byte sampled in the last cycle of the overlap. Lanes whose enable stayed high keep their contents.
- R7: The write ends on the release of any one qualifier: we_ni rising, ce1_ni rising, ce2_i falling or the lane's be_ni bit rising. A lane released early commits on its own while the other lane continues.
- R8: After reset, storage word i holds i[15:0] XOR 16'hA5A5.
- R9: Address bits at and above STORE_AW are ignored, so addresses differing only there select the same word.
- R10: starve_o is set once ce1_ni has been low for STARVE_CYC cycles with no recovery. It then stays set until reset.
- R11: A recovery restarts the starvation window. A recovery is TRC_CYC consecutive cycles with an unchanged address, or TRC_CYC consecutive cycles with ce1_ni high.
- R12: When a write's end and a read of the same word are sampled at the same edge, the read returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output strobe, active low |
| be_ni | input | 2 | Byte lane enables, active low; bit 0 lower lane |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 16 | Data bus as seen by the device |
| dq_o | output | 16 | Read data, zero on undriven lanes |
| dq_oe_o | output | 2 | Per-lane drive enable for the data bus |
| standby_o | output | 1 | 1 when deselected |
| starve_o | output | 1 | Sticky hidden-refresh starvation flag |

## Verification
A lane's write commit and a read of the same word can land on the same clock edge. The bench provokes this by raising we_ni while keeping the address and pulling oe_ni low, and it expects the fresh data in that very cycle. The same overlap is exercised per lane. Releasing one lane's enable commits that lane while the other lane keeps writing, and the bench judges each lane's byte against a shadow array updated by the commit rule.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             ce1_n;
    logic             ce2;
    logic             we_n;
    logic             oe_n;
    logic [LANES-1:0] be_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, be_n: '1};

  function automatic logic [DATA_W-1:0] init_word(input int unsigned idx);
    return DATA_W'(idx) ^ DATA_W'(16'hA5A5);
  endfunction
endpackage

// File: rtl/psram_pin_sampler.sv
module psram_pin_sampler
  import psram_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output ctl_t              ctl_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] dq_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q_o  <= CTL_IDLE;
      addr_q_o <= '0;
      dq_q_o   <= '0;
    end else begin
      ctl_q_o  <= ctl_i;
      addr_q_o <= addr_i;
      dq_q_o   <= dq_i;
    end
  end
endmodule

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
(
  input  ctl_t             ctl_q_i,
  input  logic             ce1_n_pin_i,
  input  logic             ce2_pin_i,
  input  logic             we_n_pin_i,
  input  logic [LANES-1:0] be_n_pin_i,
  output logic             standby_o,
  output logic [LANES-1:0] rd_lane_o,
  output logic [LANES-1:0] wr_lane_o
);
  logic sel_q;
  assign sel_q     = !ctl_q_i.ce1_n && ctl_q_i.ce2 && !(&ctl_q_i.be_n);
  assign standby_o = !sel_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic act_q, act_pin;
    // overlap seen last edge vs overlap on the pins now
    assign act_q   = !ctl_q_i.ce1_n && ctl_q_i.ce2 && !ctl_q_i.we_n && !ctl_q_i.be_n[l];
    assign act_pin = !ce1_n_pin_i && ce2_pin_i && !we_n_pin_i && !be_n_pin_i[l];
    assign rd_lane_o[l] = sel_q && ctl_q_i.we_n && !ctl_q_i.oe_n && !ctl_q_i.be_n[l];
    assign wr_lane_o[l] = act_q && !act_pin;
  end
endmodule

// File: rtl/psram_array.sv
module psram_array
  import psram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANES-1:0]  wr_lane_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lane_i[l]) mem[addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data_o = mem[addr_i];
endmodule

// File: rtl/psram_starve_mon.sv
module psram_starve_mon #(
  parameter int ADDR_W     = 18,
  parameter int TRC_CYC    = 11,
  parameter int STARVE_CYC = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce1_n_q_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  output logic              starve_o
);
  localparam int HW = $clog2(TRC_CYC + 1);
  localparam int SW = $clog2(STARVE_CYC + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(TRC_CYC);
  localparam logic [SW-1:0] WIN_MAX  = SW'(STARVE_CYC);

  logic [ADDR_W-1:0] addr_prev;
  logic [HW-1:0]     hold_cnt, cehi_cnt;
  logic [SW-1:0]     win_cnt;
  logic              addr_chg, recover;

  assign addr_chg = addr_q_i != addr_prev;
  assign recover  = (hold_cnt == HOLD_MAX) || (cehi_cnt == HOLD_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_prev <= '0;
      hold_cnt  <= '0;
      cehi_cnt  <= '0;
      win_cnt   <= '0;
      starve_o  <= 1'b0;
    end else begin
      addr_prev <= addr_q_i;
      if (addr_chg)                  hold_cnt <= '0;
      else if (hold_cnt != HOLD_MAX) hold_cnt <= hold_cnt + 1'b1;
      if (!ce1_n_q_i)                cehi_cnt <= '0;
      else if (cehi_cnt != HOLD_MAX) cehi_cnt <= cehi_cnt + 1'b1;
      if (recover)                              win_cnt <= '0;
      else if (!ce1_n_q_i && win_cnt != WIN_MAX) win_cnt <= win_cnt + 1'b1;
      if (win_cnt == WIN_MAX) starve_o <= 1'b1;
    end
  end
endmodule

// File: rtl/psram_model.sv
module psram_model
  import psram_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int STORE_AW   = 10,
  parameter int TRC_CYC    = 11,
  parameter int STARVE_CYC = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [LANES-1:0]  be_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe_o,
  output logic              standby_o,
  output logic              starve_o
);
  ctl_t              ctl_pin, ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q, rd_data;
  logic [LANES-1:0]  rd_lane, lane_wr;

  assign ctl_pin = '{ce1_n: ce1_ni, ce2: ce2_i, we_n: we_ni, oe_n: oe_ni, be_n: be_ni};

  psram_pin_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk_i, .rst_ni, .ctl_i(ctl_pin), .addr_i, .dq_i,
    .ctl_q_o(ctl_q), .addr_q_o(addr_q), .dq_q_o(dq_q)
  );

  psram_decode u_decode (
    .ctl_q_i(ctl_q), .ce1_n_pin_i(ce1_ni), .ce2_pin_i(ce2_i), .we_n_pin_i(we_ni),
    .be_n_pin_i(be_ni), .standby_o, .rd_lane_o(rd_lane), .wr_lane_o(lane_wr)
  );

  psram_array #(.AW(STORE_AW)) u_array (
    .clk_i, .rst_ni, .addr_i(addr_q[STORE_AW-1:0]), .wr_lane_i(lane_wr),
    .wr_data_i(dq_q), .rd_data_o(rd_data)
  );

  psram_starve_mon #(.ADDR_W(ADDR_W), .TRC_CYC(TRC_CYC), .STARVE_CYC(STARVE_CYC)) u_starve (
    .clk_i, .rst_ni, .ce1_n_q_i(ctl_q.ce1_n), .addr_q_i(addr_q), .starve_o
  );

  assign dq_oe_o = rd_lane;
  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign dq_o[l*LANE_W +: LANE_W] = rd_lane[l] ? rd_data[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/psram_model_chk.sv
module psram_model_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              standby_i,
  input logic [1:0]        dq_oe_i,
  input logic [15:0]       dq_i,
  input logic              starve_i,
  input logic              we_q_i,
  input logic [ADDR_W-1:0] addr_q_i,
  input logic [1:0]        commit_i
);
  a_r1_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |-> dq_oe_i == 2'b00);

  a_r5_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_q_i && !standby_i) |-> dq_oe_i == 2'b00);

  a_r3_low_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_i[0] |-> dq_i[7:0] == 8'h00);

  a_r3_high_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_i[1] |-> dq_i[15:8] == 8'h00);

  a_r10_starve_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    starve_i |=> starve_i);

  a_r6_data_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_q_i) && $stable(dq_oe_i) && $past(commit_i) == 2'b00) |-> $stable(dq_i));
endmodule

bind psram_model psram_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_o), .dq_oe_i(dq_oe_o), .dq_i(dq_o),
  .starve_i(starve_o), .we_q_i(ctl_q.we_n), .addr_q_i(addr_q), .commit_i(lane_wr)
);

// File: tb/psram_model_tb.sv
`timescale 1ns/1ps
module psram_model_tb;
  localparam int ADDR_W   = 18;
  localparam int STORE_AW = 10;
  localparam int DEPTH    = 1 << STORE_AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic              ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]        be_n = 2'b11;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       dq_in = '0;
  logic [15:0]       dq_out;
  logic [1:0]        dq_oe;
  logic              standby, starve;

  psram_model #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) u_dut (
    .clk_i(clk), .rst_ni, .ce1_ni(ce1_n), .ce2_i(ce2), .we_ni(we_n), .oe_ni(oe_n),
    .be_ni(be_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .standby_o(standby), .starve_o(starve)
  );

  typedef struct {
    bit          chk;
    logic [15:0] dq;
    logic [1:0]  oe;
    logic        stby;
    bit          chk_st;
    logic        st;
  } item_t;

  item_t item_q[$];
  string tag_q[$];
  int    n_vec = 0, n_bad = 0;

  logic [15:0] shadow [DEPTH];
  logic              pv_c1 = 1'b1, pv_c2 = 1'b0, pv_we = 1'b1;
  logic [1:0]        pv_be = 2'b11;
  logic [ADDR_W-1:0] pv_a = '0;
  logic [15:0]       pv_d = '0;

  function automatic bit lane_act(logic c1, logic c2, logic we, logic [1:0] be, int l);
    return !c1 && c2 && !we && !be[l];
  endfunction

  task automatic drive(input logic c1, input logic c2, input logic we, input logic oe,
                       input logic [1:0] be, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                       input bit chk, input bit chk_st, input logic st, input string tag);
    item_t it;
    bit sel;
    @(negedge clk);
    ce1_n = c1; ce2 = c2; we_n = we; oe_n = oe; be_n = be; addr = a; dq_in = d;
    // lane commit on end of its overlap (R6, R7)
    for (int l = 0; l < 2; l++)
      if (lane_act(pv_c1, pv_c2, pv_we, pv_be, l) && !lane_act(c1, c2, we, be, l))
        shadow[pv_a[STORE_AW-1:0]][l*8 +: 8] = pv_d[l*8 +: 8];
    sel = !c1 && c2 && (be != 2'b11);
    it.chk = chk; it.chk_st = chk_st; it.st = st;
    it.stby = !sel;
    for (int l = 0; l < 2; l++) begin
      it.oe[l] = sel && we && !oe && !be[l];
      it.dq[l*8 +: 8] = it.oe[l] ? shadow[a[STORE_AW-1:0]][l*8 +: 8] : 8'h00;
    end
    item_q.push_back(it);
    tag_q.push_back(tag);
    pv_c1 = c1; pv_c2 = c2; pv_we = we; pv_be = be; pv_a = a; pv_d = d;
  endtask

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per driven cycle
  always @(posedge clk) begin
    item_t it;
    string tg;
    #1;
    if (item_q.size() > 0) begin
      it = item_q.pop_front();
      tg = tag_q.pop_front();
      if (it.chk) begin
        cmp(tg, "dq_o", dq_out, it.dq);
        cmp(tg, "dq_oe_o", {14'd0, dq_oe}, {14'd0, it.oe});
        cmp(tg, "standby_o", {15'd0, standby}, {15'd0, it.stby});
      end
      if (it.chk_st) cmp(tg, "starve_o", {15'd0, starve}, {15'd0, it.st});
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] be, input string tag);
    drive(1'b0, 1'b1, 1'b1, 1'b0, be, a, 16'h0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++)
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, ((i / 2) % 2 == 1) ? 18'd20 : 18'd21, 16'h0,
            1'b0, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 16'(i) ^ 16'hA5A5; // R8
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // reset state, R1
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R1");
    rd(18'd3, 2'b00, "R8");
    rd(18'd700, 2'b00, "R2");
    rd(18'd3, 2'b10, "R3");
    rd(18'd3, 2'b01, "R2");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 18'd3, 16'h0, 1'b1, 1'b0, 1'b0, "R4");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 18'd3, 16'h0, 1'b1, 1'b0, 1'b0, "R1");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 18'd3, 16'h0, 1'b1, 1'b0, 1'b0, "R1");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 18'd3, 16'h0, 1'b1, 1'b0, 1'b0, "R1");
    // full write with oe low, ended by we rising into same-word read (R5, R12)
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 18'd10, 16'h1234, 1'b1, 1'b0, 1'b0, "R5");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 18'd10, 16'h1234, 1'b1, 1'b0, 1'b0, "R5");
    rd(18'd10, 2'b00, "R12");
    // upper lane only, ended by ce1 (R6, R7)
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 18'd11, 16'hBEEF, 1'b1, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 18'd11, 16'h0000, 1'b1, 1'b0, 1'b0, "R7");
    rd(18'd11, 2'b00, "R6");
    // lower lane only, ended by ce2 (R7)
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 18'd12, 16'h77CC, 1'b1, 1'b0, 1'b0, "R7");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 18'd12, 16'h0000, 1'b1, 1'b0, 1'b0, "R7");
    rd(18'd12, 2'b00, "R7");
    // both lanes, ended by enables (R7)
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 18'd13, 16'h5AC3, 1'b1, 1'b0, 1'b0, "R7");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 18'd13, 16'h0000, 1'b1, 1'b0, 1'b0, "R7");
    rd(18'd13, 2'b00, "R7");
    // lower lane released early, upper continues (R7)
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 18'd14, 16'h1111, 1'b1, 1'b0, 1'b0, "R7");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 18'd14, 16'h2222, 1'b1, 1'b0, 1'b0, "R7");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 18'd14, 16'h3333, 1'b1, 1'b0, 1'b0, "R7");
    rd(18'd14, 2'b00, "R7");
    // aliasing of upper address bits (R9)
    rd(18'(DEPTH + 10), 2'b00, "R9");
    rd(18'(4 * DEPTH + 14), 2'b00, "R9");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R10");
    // starvation window with recovery (R11)
    toggle(2000);
    for (int i = 0; i < 20; i++)
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd21, 16'h0, 1'b0, 1'b0, 1'b0, "R11");
    toggle(2900);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd20, 16'h0, 1'b1, 1'b1, 1'b0, "R11");
    toggle(200);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 18'd21, 16'h0, 1'b1, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 30; i++)
      drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0, 1'b0, 1'b0, 1'b0, "R10");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0, 1'b1, 1'b1, 1'b1, "R10");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule